// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of each beat of a short memory burst. A load cycle captures a complete address together with the access type (read or write), and it also captures the burst order. Each following advance cycle steps only the low address bits inside a four-word window. Those bits follow either a linear order (modulo add) or an interleaved order (XOR of the start value with a beat index). The bits above the window stay fixed for the whole burst.

A memory controller or a synchronous SRAM front end places this block in front of its array. The array reads the registered address, the type and the valid flag one cycle after the command. A stall input freezes every register, which stretches the current cycle. A load that arrives while the chip selects do not all agree ends the burst, and the block stays idle until the next load.

Top module: `burst_addr_seq`

## Requirements
- R1: When `stall`=0, `step`=0 and every bit of `sel` is 1, the outputs after the next clock are `acc_addr`=`addr_in`, `acc_wr`=`wr_req` and `acc_vld`=1.
- R2: With `order_mode`=0 at load, beat k (k=1,2,3) after the load start value s carries low bits (s+k) mod 4. The upper bits `acc_addr[ADDR_W-1:2]` keep their loaded value.
- R3: With `order_mode`=1 at load, beat k (k=1,2,3) carries low bits s XOR k. The upper bits are unchanged.
- R4: Advancing past the fourth beat wraps to the start value and then repeats the same order. Beat k uses k mod 4.
- R5: During an advance (`stall`=0, `step`=1, burst active), `sel` and `wr_req` have no effect. `acc_wr` keeps the type that was latched at load.
- R6: While `stall`=1, `acc_addr`, `acc_wr` and `acc_vld` hold their values. The burst resumes from the same beat once `stall` returns to 0.
- R7: An advance while `acc_vld`=0 is ignored. `acc_vld` stays 0 and `acc_addr` and `acc_wr` hold their values.
- R8: A load cycle (`stall`=0, `step`=0) in which any bit of `sel` is 0 gives `acc_vld`=0 after the next clock.
- R9: `order_mode` is sampled only on a load. Changing it in the middle of a burst leaves that burst's order unchanged.
- R10: While `rst_n`=0, and after reset is released, the outputs read `acc_addr`=0, `acc_wr`=0 and `acc_vld`=0 until the first load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | 1 freezes all state for this cycle |
| step | input | 1 | 1 advances the burst, 0 loads a new address |
| sel | input | SEL_W | Chip select qualifiers, all must be 1 to start an access |
| wr_req | input | 1 | Access type at load: 1 write, 0 read |
| order_mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | Full start address |
| acc_addr | output | ADDR_W | Address of the current beat |
| acc_wr | output | 1 | Latched access type of the burst |
| acc_vld | output | 1 | A burst beat is active |

## Verification
The hardest case to reach is the one where the qualifiers change in the middle of a burst. The stimulus reaches it by driving, on every advance beat of a sweep, the opposite write type, the opposite order mode and a rotating chip-select pattern that includes deasserted selects. A correct design must ignore all of these. The sweep covers all four start values, both orders and both access types, and it runs six beats per burst so that the wrap is exercised. Separate sequences stall the block in the middle of a burst while presenting a conflicting load, and issue advances after a deselect.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_ord_e;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_DESEL = 3'd2,
    OP_ADV   = 3'd3,
    OP_IDLE  = 3'd4
  } seq_op_e;

endpackage

// File: rtl/burst_offset_gen.sv
module burst_offset_gen
  import burst_seq_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic [BURST_W-1:0] start,
  input  logic [BURST_W-1:0] beat,
  input  burst_ord_e         ord,
  output logic [BURST_W-1:0] low_addr
);

  logic [BURST_W-1:0] lin_val;
  logic [BURST_W-1:0] ilv_val;

  always_comb begin
    lin_val = start + beat;
  end

  for (genvar b = 0; b < BURST_W; b++) begin : g_xor
    assign ilv_val[b] = start[b] ^ beat[b];
  end

  always_comb begin
    if (ord == ORD_INTERLEAVE) low_addr = ilv_val;
    else                       low_addr = lin_val;
  end

endmodule

// File: rtl/burst_op_decode.sv
module burst_op_decode
  import burst_seq_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             stall,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  input  logic             active,
  output seq_op_e          op
);

  logic all_sel;

  always_comb begin
    all_sel = &sel;
  end

  always_comb begin
    if (stall)        op = OP_HOLD;
    else if (!step)   op = all_sel ? OP_LOAD : OP_DESEL;
    else if (active)  op = OP_ADV;
    else              op = OP_IDLE;
  end

endmodule

// File: rtl/burst_state_regs.sv
module burst_state_regs
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  seq_op_e             op,
  input  logic [ADDR_W-1:0]   addr_in,
  input  logic                wr_req,
  input  logic                order_mode,
  input  logic [BURST_W-1:0]  adv_low,
  output logic [BURST_W-1:0]  start_q,
  output logic [BURST_W-1:0]  beat_q,
  output burst_ord_e          ord_q,
  output logic [ADDR_W-1:0]   addr_q,
  output logic                wr_q,
  output logic                vld_q
);

  localparam int UP_W = ADDR_W - BURST_W;

  logic [BURST_W-1:0] start_d;
  logic [BURST_W-1:0] beat_d;
  burst_ord_e         ord_d;
  logic [ADDR_W-1:0]  addr_d;
  logic               wr_d;
  logic               vld_d;

  always_comb begin
    start_d = start_q;
    beat_d  = beat_q;
    ord_d   = ord_q;
    addr_d  = addr_q;
    wr_d    = wr_q;
    vld_d   = vld_q;
    unique case (op)
      OP_LOAD: begin
        start_d = addr_in[BURST_W-1:0];
        beat_d  = '0;
        ord_d   = burst_ord_e'(order_mode);
        addr_d  = addr_in;
        wr_d    = wr_req;
        vld_d   = 1'b1;
      end
      OP_DESEL: begin
        vld_d   = 1'b0;
      end
      OP_ADV: begin
        beat_d  = beat_q + 1'b1;
        addr_d  = {addr_q[ADDR_W-1:BURST_W], adv_low};
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
      ord_q   <= ORD_LINEAR;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      beat_q  <= beat_d;
      ord_q   <= ord_d;
      addr_q  <= addr_d;
      wr_q    <= wr_d;
      vld_q   <= vld_d;
    end
  end

  logic [UP_W-1:0] unused_up;
  assign unused_up = addr_in[ADDR_W-1:BURST_W];

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2,
  parameter int SEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              step,
  input  logic [SEL_W-1:0]  sel,
  input  logic              wr_req,
  input  logic              order_mode,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_wr,
  output logic              acc_vld
);

  seq_op_e            op;
  logic [BURST_W-1:0] start_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] beat_nx;
  logic [BURST_W-1:0] adv_low;
  burst_ord_e         ord_q;

  assign beat_nx = beat_q + 1'b1;

  burst_op_decode #(.SEL_W(SEL_W)) dec_i (
    .stall  (stall),
    .step   (step),
    .sel    (sel),
    .active (acc_vld),
    .op     (op)
  );

  burst_offset_gen #(.BURST_W(BURST_W)) off_i (
    .start    (start_q),
    .beat     (beat_nx),
    .ord      (ord_q),
    .low_addr (adv_low)
  );

  burst_state_regs #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .addr_in    (addr_in),
    .wr_req     (wr_req),
    .order_mode (order_mode),
    .adv_low    (adv_low),
    .start_q    (start_q),
    .beat_q     (beat_q),
    .ord_q      (ord_q),
    .addr_q     (acc_addr),
    .wr_q       (acc_wr),
    .vld_q      (acc_vld)
  );

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2,
  parameter int SEL_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall,
  input logic              step,
  input logic [SEL_W-1:0]  sel,
  input logic              wr_req,
  input logic              order_mode,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_wr,
  input logic              acc_vld
);

  AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !step && (&sel)) |=> (acc_vld && acc_addr == $past(addr_in) && acc_wr == $past(wr_req))); // R1

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && step && acc_vld) |=> $stable(acc_addr[ADDR_W-1:BURST_W])); // R2

  AST_TYPE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && step && acc_vld) |=> ($stable(acc_wr) && acc_vld)); // R5

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(acc_addr) && $stable(acc_wr) && $stable(acc_vld))); // R6

  AST_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && step && !acc_vld) |=> (!acc_vld && $stable(acc_addr))); // R7

  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !step && !(&sel)) |=> !acc_vld); // R8

  always_comb begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!acc_vld); // R10
    end
  end

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
  .ADDR_W (ADDR_W),
  .BURST_W(BURST_W),
  .SEL_W  (SEL_W)
) chk_i (.*);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

  localparam int ADDR_W = 17;
  localparam int SEL_W  = 3;

  logic              clk;
  logic              rst_n;
  logic              stall;
  logic              step;
  logic [SEL_W-1:0]  sel;
  logic              wr_req;
  logic              order_mode;
  logic [ADDR_W-1:0] addr_in;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_wr;
  logic              acc_vld;

  int n_run;
  int n_fail;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BURST_W(2), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .step(step), .sel(sel),
    .wr_req(wr_req), .order_mode(order_mode), .addr_in(addr_in),
    .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_vld(acc_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one command cycle, then sample just after the capturing edge.
  task automatic cyc(input logic st, input logic sp, input logic [SEL_W-1:0] s,
                     input logic w, input logic m, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    stall = st; step = sp; sel = s; wr_req = w; order_mode = m; addr_in = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    n_run = 0; n_fail = 0;
    rst_n = 1'b0; stall = 1'b0; step = 1'b1; sel = '0;
    wr_req = 1'b0; order_mode = 1'b0; addr_in = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 vld in reset", acc_vld, 0);
    check("R10 addr in reset", acc_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10 vld after reset", acc_vld, 0);
    check("R10 wr after reset", acc_wr, 0);

    // Sweep: start value x order x access type, six beats (wraps).
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int w = 0; w < 2; w++) begin
          logic [ADDR_W-3:0] up;
          logic [1:0] exp_low;
          up = (ADDR_W-2)'((s * 4 + m * 2 + w) * 2731 + 5);
          cyc(1'b0, 1'b0, '1, w[0], m[0], {up, s[1:0]});
          check("R1 load addr", acc_addr, {up, s[1:0]});
          check("R1 load type", acc_wr, w[0]);
          check("R1 load valid", acc_vld, 1);
          for (int k = 1; k <= 6; k++) begin
            // Opposite type, opposite mode, varying selects: all ignored (R5, R9).
            cyc(1'b0, 1'b1, SEL_W'(k), ~w[0], ~m[0], '0);
            if (m == 1) exp_low = s[1:0] ^ k[1:0];
            else        exp_low = s[1:0] + k[1:0];
            if (k >= 4)      check("R4 wrap beat", acc_addr, {up, exp_low});
            else if (m == 1) check("R3 interleaved beat", acc_addr, {up, exp_low});
            else             check("R2 linear beat", acc_addr, {up, exp_low});
            check("R5 type held", acc_wr, w[0]);
            if (k == 2) check("R9 order kept", acc_addr[1:0], exp_low);
          end
        end
      end
    end

    // Stall in mid-burst with a conflicting load presented.
    cyc(1'b0, 1'b0, '1, 1'b1, 1'b0, 17'h1ABC2);
    cyc(1'b0, 1'b1, '1, 1'b0, 1'b0, '0);
    check("R2 linear beat pre-stall", acc_addr, 17'h1ABC3);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 1'b0, '1, 1'b0, 1'b1, 17'h00005);
      check("R6 addr held", acc_addr, 17'h1ABC3);
      check("R6 type held", acc_wr, 1);
      check("R6 valid held", acc_vld, 1);
    end
    cyc(1'b0, 1'b1, '0, 1'b0, 1'b0, '0);
    check("R6 resume beat", acc_addr, 17'h1ABC0);

    // Deselect, then advances are ignored.
    cyc(1'b0, 1'b0, 3'b101, 1'b0, 1'b0, 17'h00003);
    check("R8 deselect", acc_vld, 0);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 1'b1, '1, 1'b0, 1'b1, 17'h0FFFF);
      check("R7 idle vld", acc_vld, 0);
      check("R7 idle addr", acc_addr, 17'h1ABC0);
      check("R7 idle type", acc_wr, 1);
    end
    cyc(1'b0, 1'b0, '1, 1'b0, 1'b1, 17'h00041);
    check("R1 reload after deselect", acc_addr, 17'h00041);
    cyc(1'b0, 1'b1, '1, 1'b1, 1'b0, '0);
    check("R3 interleaved after reload", acc_addr, 17'h00040);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule